// File: doc/BRIEF.md
# DRAM refresh and initialization sequencer

This block brings an EDO DRAM up after reset and keeps it refreshed afterwards. It shares the row strobe, column strobe and write strobe with the access controller. It asks for those lines through a request/grant handshake and drives them only while the grant is held. After reset it waits out a start-up pause. It then runs a fixed number of warm-up refresh cycles. Once they are done it raises a ready output, and the access controller must wait for that output before it issues host cycles.

In normal operation an interval counter schedules one column-before-row refresh per interval. Every refresh cycle pulls the column strobe low first, then the row strobe, while the write strobe stays high. The memory keeps its own row counter, so no address is produced. If the grant is late, missed intervals are held in a small saturating backlog and are issued back to back under one grant. If no refresh row strobe has been issued for too long, ready drops and the warm-up is repeated.

A sleep request places the memory in self-refresh. Both strobes are held low for at least a minimum time, and the sleep is acknowledged while they are held. On exit, both strobes stay high for a precharge time before the bus is released.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the row, column and write strobes are high and rfsh_req, sleep_ack and mem_ready are low.
- R2: rfsh_req stays low for PAUSE_CYC clock cycles after reset is released and rises within two cycles after that.
- R3: mem_ready rises only after exactly WARM_CNT refresh row-strobe pulses have been issued since mem_ready was last low (or since reset).
- R4: Every falling edge of the row strobe comes after the column strobe has been low for at least T_CSR cycles. The write strobe is never driven low.
- R5: In a refresh cycle the row strobe stays low for at least T_RAS cycles, and the column strobe returns high in the same cycle as the row strobe.
- R6: The strobes are low only while rfsh_gnt is high. After a refresh, rfsh_req falls only after both strobes have been high for at least T_PRE cycles.
- R7: When the grant comes promptly, exactly one refresh is issued per INTERVAL_CYC cycles.
- R8: Refresh intervals that expire while the grant is withheld are queued up to MAX_BACKLOG. The queued refreshes are issued back to back under one grant, and intervals beyond that count are dropped.
- R9: sleep_ack is high only while both the row and column strobes are low, and it stays high for as long as sleep_req is held.
- R10: In self-refresh the row strobe stays low for at least SELF_MIN cycles, even if sleep_req is withdrawn earlier.
- R11: After self-refresh exit, both strobes stay high for at least SELF_PRE cycles before rfsh_req falls.
- R12: If no refresh row strobe has fallen for IDLE_LIMIT cycles while ready, mem_ready falls and the warm-up is repeated. Otherwise mem_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_req | output | 1 | Requests the shared strobe lines |
| rfsh_gnt | input | 1 | Grant from the access controller, held until rfsh_req falls |
| sleep_req | input | 1 | Asks for self-refresh |
| sleep_ack | output | 1 | Memory is held in self-refresh |
| mem_ready | output | 1 | Warm-up complete; host cycles allowed |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, held high |

## Verification
The bench targets the following corner cases:

- **Withheld grant.** The grant is held back for chosen fractions of the interval. A backlog that miscounts, fails to saturate, or releases the bus between queued refreshes would show a wrong burst length.
- **Early sleep withdrawal.** sleep_req is withdrawn one cycle after the acknowledge. A design that exits at once would cut the self-refresh row-strobe pulse short.
- **Strobe order.** Every strobe edge is watched. A swapped order or a column strobe that rises late breaks the ordering checks.
- **Long starvation.** The grant is withheld past the idle limit. A design without the idle watch would keep mem_ready high over a memory that has lost its contents.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_WAIT_GNT,
        ST_CAS_SETUP,
        ST_RAS_LOW,
        ST_PRECHG,
        ST_SR_ENTRY,
        ST_SR_HOLD,
        ST_SR_EXIT
    } rfsh_state_e;

    typedef enum logic {
        OP_REFRESH,
        OP_SLEEP
    } rfsh_op_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold values 0..n
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic strobe_t strobes_for(input rfsh_state_e s);
        strobe_t v;
        v.ras_n = 1'b1;
        v.cas_n = 1'b1;
        v.we_n  = 1'b1;
        case (s)
            ST_CAS_SETUP, ST_SR_ENTRY: v.cas_n = 1'b0;
            ST_RAS_LOW, ST_SR_HOLD: begin
                v.cas_n = 1'b0;
                v.ras_n = 1'b0;
            end
            default: ;
        endcase
        return v;
    endfunction

    function automatic logic owns_bus(input rfsh_state_e s);
        case (s)
            ST_WAIT_GNT, ST_CAS_SETUP, ST_RAS_LOW, ST_PRECHG,
            ST_SR_ENTRY, ST_SR_HOLD, ST_SR_EXIT: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic in_self_refresh(input rfsh_state_e s);
        return (s == ST_SR_ENTRY) || (s == ST_SR_HOLD) || (s == ST_SR_EXIT);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned MAX_BACKLOG  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic served,
    output logic backlog_nz
);
    localparam int unsigned CNT_W = cnt_w(INTERVAL_CYC - 1);
    localparam int unsigned BL_W  = cnt_w(MAX_BACKLOG);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL_CYC - 1);
    localparam logic [BL_W-1:0]  BL_MAX   = BL_W'(MAX_BACKLOG);

    logic [CNT_W-1:0] cnt_q;
    logic [BL_W-1:0]  backlog_q;
    logic [BL_W-1:0]  backlog_d;
    logic             wrap;
    logic             add;
    logic             sub;

    assign wrap = (cnt_q == CNT_LAST);
    assign add  = wrap && (backlog_q < BL_MAX);
    assign sub  = served && (backlog_q != '0);

    always_comb begin
        backlog_d = backlog_q;
        if (add && !sub)
            backlog_d = backlog_q + 1'b1;
        else if (sub && !add)
            backlog_d = backlog_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q     <= '0;
            backlog_q <= '0;
        end else begin
            cnt_q     <= wrap ? '0 : cnt_q + 1'b1;
            backlog_q <= backlog_d;
        end
    end

    assign backlog_nz = (backlog_q != '0);

    // R8: the queue never holds more than its limit
    a_r8_backlog_capped: assert property (@(posedge clk) disable iff (rst)
        backlog_q <= BL_MAX);

    // R8: at most one interval is added per cycle
    a_r8_backlog_single_step: assert property (@(posedge clk) disable iff (rst)
        (backlog_q > $past(backlog_q)) |-> (backlog_q == $past(backlog_q) + 1'b1));

endmodule

// File: rtl/rfsh_idle_watch.sv
module rfsh_idle_watch
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned IDLE_LIMIT = 1640000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ras_fall,
    output logic idle_expire
);
    localparam int unsigned W = cnt_w(IDLE_LIMIT - 1);
    localparam logic [W-1:0] LAST = W'(IDLE_LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en || ras_fall)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign idle_expire = en && !ras_fall && (cnt_q == LAST);

    // R12: the counter restarts whenever a refresh row strobe falls
    a_r12_restart_on_fall: assert property (@(posedge clk) disable iff (rst)
        ras_fall |=> (cnt_q == '0));

endmodule

// File: rtl/rfsh_strobe_engine.sv
module rfsh_strobe_engine
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC = 20000,
    parameter int unsigned WARM_CNT  = 8,
    parameter int unsigned T_CSR     = 1,
    parameter int unsigned T_RAS     = 5,
    parameter int unsigned T_PRE     = 4,
    parameter int unsigned SELF_MIN  = 10000,
    parameter int unsigned SELF_PRE  = 13
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rfsh_gnt,
    input  logic    sleep_req,
    input  logic    backlog_nz,
    input  logic    idle_expire,
    output logic    rfsh_req,
    output logic    sleep_ack,
    output logic    ready,
    output logic    served,
    output logic    ras_fall,
    output logic    sr_active,
    output strobe_t strb
);
    localparam int unsigned TMR_MAX = max2(max2(max2(PAUSE_CYC, SELF_MIN), max2(T_CSR, T_RAS)),
                                           max2(T_PRE, SELF_PRE));
    localparam int unsigned TMR_W  = cnt_w(TMR_MAX);
    localparam int unsigned WARM_W = cnt_w(WARM_CNT);
    localparam logic [TMR_W-1:0]  PAUSE_LAST = TMR_W'(PAUSE_CYC - 1);
    localparam logic [TMR_W-1:0]  CSR_LAST   = TMR_W'(T_CSR - 1);
    localparam logic [TMR_W-1:0]  RAS_LAST   = TMR_W'(T_RAS - 1);
    localparam logic [TMR_W-1:0]  PRE_LAST   = TMR_W'(T_PRE - 1);
    localparam logic [TMR_W-1:0]  SRMIN_LAST = TMR_W'(SELF_MIN - 1);
    localparam logic [TMR_W-1:0]  SRPRE_LAST = TMR_W'(SELF_PRE - 1);
    localparam logic [WARM_W-1:0] WARM_INIT  = WARM_W'(WARM_CNT);

    rfsh_state_e       state_q;
    rfsh_op_e          op_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [WARM_W-1:0] warm_q;
    logic              ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PAUSE;
            op_q    <= OP_REFRESH;
            tmr_q   <= '0;
            warm_q  <= WARM_INIT;
            ready_q <= 1'b0;
        end else begin
            case (state_q)
                ST_PAUSE: begin
                    if (tmr_q == PAUSE_LAST) begin
                        tmr_q   <= '0;
                        op_q    <= OP_REFRESH;
                        state_q <= ST_WAIT_GNT;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    tmr_q <= '0;
                    if (idle_expire) begin
                        ready_q <= 1'b0;
                        warm_q  <= WARM_INIT;
                        op_q    <= OP_REFRESH;
                        state_q <= ST_WAIT_GNT;
                    end else if (backlog_nz) begin
                        op_q    <= OP_REFRESH;
                        state_q <= ST_WAIT_GNT;
                    end else if (sleep_req) begin
                        op_q    <= OP_SLEEP;
                        state_q <= ST_WAIT_GNT;
                    end
                end
                ST_WAIT_GNT: begin
                    if (idle_expire) begin
                        ready_q <= 1'b0;
                        warm_q  <= WARM_INIT;
                        op_q    <= OP_REFRESH;
                    end
                    if (op_q == OP_SLEEP && !idle_expire && !sleep_req)
                        state_q <= ST_IDLE;
                    else if (rfsh_gnt)
                        state_q <= (op_q == OP_SLEEP && !idle_expire) ? ST_SR_ENTRY : ST_CAS_SETUP;
                end
                ST_CAS_SETUP: begin
                    if (tmr_q == CSR_LAST) begin
                        tmr_q   <= '0;
                        state_q <= ST_RAS_LOW;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_RAS_LOW: begin
                    if (tmr_q == RAS_LAST) begin
                        tmr_q   <= '0;
                        state_q <= ST_PRECHG;
                        if (!ready_q && warm_q != '0)
                            warm_q <= warm_q - 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_PRECHG: begin
                    if (tmr_q == PRE_LAST) begin
                        tmr_q <= '0;
                        if (!ready_q) begin
                            if (warm_q != '0) begin
                                state_q <= ST_CAS_SETUP;
                            end else begin
                                ready_q <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end else if (backlog_nz) begin
                            state_q <= ST_CAS_SETUP;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_SR_ENTRY: begin
                    if (tmr_q == CSR_LAST) begin
                        tmr_q   <= '0;
                        state_q <= ST_SR_HOLD;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_SR_HOLD: begin
                    if (tmr_q >= SRMIN_LAST) begin
                        if (!sleep_req) begin
                            tmr_q   <= '0;
                            state_q <= ST_SR_EXIT;
                        end
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_SR_EXIT: begin
                    if (tmr_q == SRPRE_LAST) begin
                        tmr_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    tmr_q   <= '0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign strb      = strobes_for(state_q);
    assign rfsh_req  = owns_bus(state_q);
    assign sleep_ack = (state_q == ST_SR_HOLD);
    assign sr_active = in_self_refresh(state_q);
    assign ready     = ready_q;
    assign served    = (state_q == ST_RAS_LOW) && (tmr_q == RAS_LAST);
    assign ras_fall  = (state_q == ST_CAS_SETUP) && (tmr_q == CSR_LAST);

    // R4: column strobe leads the row strobe
    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |-> (!strb.cas_n && $past(!strb.cas_n)));

    // R5: both strobes return high together
    a_r5_release_together: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ras_n) |-> $rose(strb.cas_n));

    // R6: strobes are only driven under grant
    a_r6_grant_covers_strobes: assert property (@(posedge clk) disable iff (rst)
        (!strb.ras_n || !strb.cas_n) |-> rfsh_gnt);

    // R6 / R11: the request is dropped only with both strobes high
    a_r6_req_drop_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(rfsh_req) |-> ($past(strb.ras_n) && $past(strb.cas_n)));

    // R3: ready only after the warm-up count is used up
    a_r3_ready_after_warm: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> (warm_q == '0));

    // R10: self-refresh row pulse honours its minimum
    a_r10_sr_min_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(strb.ras_n) && $past(state_q == ST_SR_HOLD)) |-> ($past(tmr_q) >= SRMIN_LAST));

    // R12: an idle timeout withdraws ready
    a_r12_expire_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (idle_expire && (state_q == ST_IDLE || state_q == ST_WAIT_GNT)) |=> !ready_q);

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 20000,
    parameter int unsigned WARM_CNT     = 8,
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned MAX_BACKLOG  = 8,
    parameter int unsigned IDLE_LIMIT   = 1640000,
    parameter int unsigned T_CSR        = 1,
    parameter int unsigned T_RAS        = 5,
    parameter int unsigned T_PRE        = 4,
    parameter int unsigned SELF_MIN     = 10000,
    parameter int unsigned SELF_PRE     = 13
) (
    input  logic clk,
    input  logic rst,
    output logic rfsh_req,
    input  logic rfsh_gnt,
    input  logic sleep_req,
    output logic sleep_ack,
    output logic mem_ready,
    output logic dram_ras_n,
    output logic dram_cas_n,
    output logic dram_we_n
);
    logic    backlog_nz;
    logic    idle_expire;
    logic    served;
    logic    ras_fall;
    logic    sr_active;
    logic    ready;
    strobe_t strb;

    rfsh_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .MAX_BACKLOG  (MAX_BACKLOG)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (!ready || sr_active),
        .served     (served),
        .backlog_nz (backlog_nz)
    );

    rfsh_idle_watch #(
        .IDLE_LIMIT (IDLE_LIMIT)
    ) idle_i (
        .clk         (clk),
        .rst         (rst),
        .en          (ready && !sr_active),
        .ras_fall    (ras_fall),
        .idle_expire (idle_expire)
    );

    rfsh_strobe_engine #(
        .PAUSE_CYC (PAUSE_CYC),
        .WARM_CNT  (WARM_CNT),
        .T_CSR     (T_CSR),
        .T_RAS     (T_RAS),
        .T_PRE     (T_PRE),
        .SELF_MIN  (SELF_MIN),
        .SELF_PRE  (SELF_PRE)
    ) engine_i (
        .clk         (clk),
        .rst         (rst),
        .rfsh_gnt    (rfsh_gnt),
        .sleep_req   (sleep_req),
        .backlog_nz  (backlog_nz),
        .idle_expire (idle_expire),
        .rfsh_req    (rfsh_req),
        .sleep_ack   (sleep_ack),
        .ready       (ready),
        .served      (served),
        .ras_fall    (ras_fall),
        .sr_active   (sr_active),
        .strb        (strb)
    );

    assign mem_ready  = ready;
    assign dram_ras_n = strb.ras_n;
    assign dram_cas_n = strb.cas_n;
    assign dram_we_n  = strb.we_n;

endmodule

// File: tb/dram_rfsh_seq_tb_top.sv
module dram_rfsh_seq_tb_top;
    localparam int CLK_PERIOD   = 10;
    localparam int PAUSE_CYC    = 30;
    localparam int WARM_CNT     = 8;
    localparam int INTERVAL_CYC = 50;
    localparam int MAX_BACKLOG  = 3;
    localparam int IDLE_LIMIT   = 450;
    localparam int T_CSR        = 2;
    localparam int T_RAS        = 4;
    localparam int T_PRE        = 2;
    localparam int SELF_MIN     = 20;
    localparam int SELF_PRE     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rfsh_req, rfsh_gnt, sleep_req, sleep_ack, mem_ready;
    logic dram_ras_n, dram_cas_n, dram_we_n;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_rfsh_seq #(
        .PAUSE_CYC (PAUSE_CYC), .WARM_CNT (WARM_CNT), .INTERVAL_CYC (INTERVAL_CYC),
        .MAX_BACKLOG (MAX_BACKLOG), .IDLE_LIMIT (IDLE_LIMIT), .T_CSR (T_CSR),
        .T_RAS (T_RAS), .T_PRE (T_PRE), .SELF_MIN (SELF_MIN), .SELF_PRE (SELF_PRE)
    ) dut_i (
        .clk (clk), .rst (rst), .rfsh_req (rfsh_req), .rfsh_gnt (rfsh_gnt),
        .sleep_req (sleep_req), .sleep_ack (sleep_ack), .mem_ready (mem_ready),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    function automatic int exp_burst(input int wait_cyc);
        int n;
        n = 1 + wait_cyc / INTERVAL_CYC;
        return (n > MAX_BACKLOG) ? MAX_BACKLOG : n;
    endfunction

    // grant driver
    bit gnt_block = 0;
    int max_lat   = 0;
    initial begin
        int lat = 0;
        int wcnt = 0;
        rfsh_gnt = 1'b0;
        forever begin
            @(negedge clk);
            if (rst || !rfsh_req) begin
                rfsh_gnt = 1'b0;
                wcnt = 0;
                lat = $urandom_range(max_lat, 0);
            end else if (!rfsh_gnt && !gnt_block) begin
                if (wcnt >= lat) rfsh_gnt = 1'b1;
                else wcnt++;
            end
        end
    end

    // protocol monitor
    int  ras_falls = 0;
    int  warm_seen = 0;
    int  cas_run = 0, ras_run = 0, hi_run = 0;
    bit  p_ras = 1, p_cas = 1, p_req = 0, p_ack = 0, p_rdy = 0;
    bit  sr_seen = 0, last_sr = 0;
    always @(negedge clk) begin
        if (rst) begin
            cas_run = 0; ras_run = 0; hi_run = 0; warm_seen = 0;
            p_ras = 1; p_cas = 1; p_req = 0; p_ack = 0; p_rdy = 0; sr_seen = 0;
        end else begin
            if (p_ras && !dram_ras_n) begin
                check(!dram_cas_n && cas_run >= T_CSR, "R4 cas setup before ras", cas_run, T_CSR);
                check(dram_we_n == 1'b1, "R4 write strobe high", dram_we_n, 1);
                check(rfsh_gnt == 1'b1, "R6 grant at ras fall", rfsh_gnt, 1);
                ras_falls++;
                if (!mem_ready) warm_seen++;
            end
            if (p_cas && !dram_cas_n)
                check(rfsh_gnt == 1'b1, "R6 grant at cas fall", rfsh_gnt, 1);
            if (!p_ras && dram_ras_n) begin
                check(dram_cas_n == 1'b1, "R5 cas rises with ras", dram_cas_n, 1);
                if (sr_seen)
                    check(ras_run >= SELF_MIN, "R10 self-refresh ras low", ras_run, SELF_MIN);
                else
                    check(ras_run >= T_RAS, "R5 ras low width", ras_run, T_RAS);
                last_sr = sr_seen;
                sr_seen = 0;
            end
            if (sleep_ack && !p_ack)
                check(!dram_ras_n && !dram_cas_n, "R9 ack with both strobes low",
                      {dram_ras_n, dram_cas_n}, 0);
            if (sleep_ack) sr_seen = 1;
            if (p_req && !rfsh_req) begin
                if (last_sr)
                    check(hi_run >= SELF_PRE, "R11 exit precharge", hi_run, SELF_PRE);
                else
                    check(hi_run >= T_PRE, "R6 precharge before release", hi_run, T_PRE);
                last_sr = 0;
            end
            if (mem_ready && !p_rdy)
                check(warm_seen == WARM_CNT, "R3 warm-up cycles", warm_seen, WARM_CNT);
            if (!mem_ready && p_rdy) warm_seen = 0;
            cas_run = dram_cas_n ? 0 : cas_run + 1;
            ras_run = dram_ras_n ? 0 : ras_run + 1;
            hi_run  = (dram_ras_n && dram_cas_n) ? hi_run + 1 : 0;
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_req = rfsh_req;
            p_ack = sleep_ack; p_rdy = mem_ready;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_req(input bit level, input int limit, input string tag);
        int t = 0;
        while (rfsh_req != level && t < limit) begin step(); t++; end
        check(rfsh_req == level, tag, rfsh_req, level);
    endtask

    task automatic burst_test(input int wait_cyc);
        int base;
        wait_req(1'b0, 200, "R8 bus idle before test");
        gnt_block = 1;
        wait_req(1'b1, 200, "R8 request raised");
        repeat (wait_cyc) step();
        base = ras_falls;
        gnt_block = 0;
        step();
        wait_req(1'b0, 200, "R8 burst finished");
        check(ras_falls - base == exp_burst(wait_cyc), "R8 burst length",
              ras_falls - base, exp_burst(wait_cyc));
    endtask

    task automatic sleep_episode(input int hold, input string tag);
        int t = 0;
        wait_req(1'b0, 200, "R9 bus idle before sleep");
        sleep_req = 1'b1;
        while (!sleep_ack && t < 300) begin step(); t++; end
        check(sleep_ack == 1'b1, {tag, " R9 ack raised"}, sleep_ack, 1);
        repeat (hold) step();
        check(sleep_ack == 1'b1, {tag, " R9 ack held"}, sleep_ack, 1);
        sleep_req = 1'b0;
        t = 0;
        while (sleep_ack && t < SELF_MIN + 20) begin step(); t++; end
        check(sleep_ack == 1'b0, {tag, " R10 ack released"}, sleep_ack, 0);
    endtask

    initial begin
        int t;
        int base;
        void'($urandom(32'd4711));
        sleep_req = 1'b0;
        repeat (4) step();
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        check(!rfsh_req && !sleep_ack && !mem_ready, "R1 outputs low in reset",
              {rfsh_req, sleep_ack, mem_ready}, 0);
        rst = 1'b0;
        step();
        check(!rfsh_req && !mem_ready && dram_ras_n && dram_cas_n, "R1 first cycle after reset",
              {rfsh_req, mem_ready, dram_ras_n, dram_cas_n}, 3);
        t = 1;
        while (!rfsh_req && t < PAUSE_CYC + 20) begin step(); t++; end
        check(t >= PAUSE_CYC && t <= PAUSE_CYC + 2, "R2 start-up pause", t, PAUSE_CYC);

        t = 0;
        while (!mem_ready && t < 500) begin step(); t++; end
        check(mem_ready == 1'b1, "R3 ready after warm-up", mem_ready, 1);

        // R7: prompt grant, steady rate
        wait_req(1'b0, 200, "R7 bus idle");
        wait_req(1'b1, 200, "R7 first periodic request");
        base = ras_falls;
        repeat (10 * INTERVAL_CYC) step();
        check(ras_falls - base == 10, "R7 refreshes per window", ras_falls - base, 10);

        // R8: backlog depth and saturation
        burst_test(INTERVAL_CYC / 5);
        burst_test(INTERVAL_CYC + INTERVAL_CYC / 5);
        burst_test(2 * INTERVAL_CYC + INTERVAL_CYC / 5);
        burst_test(6 * INTERVAL_CYC + INTERVAL_CYC / 5);

        // R9 / R10 / R11: self-refresh, early and late withdrawal
        sleep_episode(1, "short sleep");
        sleep_episode(80, "long sleep");
        check(mem_ready == 1'b1, "R12 ready kept over sleep", mem_ready, 1);

        // R12: starvation beyond the idle limit forces a new warm-up
        wait_req(1'b0, 200, "R12 bus idle");
        gnt_block = 1;
        repeat (IDLE_LIMIT + 100) step();
        check(mem_ready == 1'b0, "R12 ready dropped", mem_ready, 0);
        gnt_block = 0;
        t = 0;
        while (!mem_ready && t < 400) begin step(); t++; end
        check(mem_ready == 1'b1, "R12 ready regained", mem_ready, 1);

        // mixed random traffic
        max_lat = 4;
        for (int i = 0; i < 15; i++) begin
            repeat ($urandom_range(150, 0)) step();
            if ($urandom_range(1, 0) == 1)
                sleep_episode($urandom_range(40, 0), "random sleep");
        end
        repeat (200) step();
        check(mem_ready == 1'b1, "R12 ready stays high under service", mem_ready, 1);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

endmodule